// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block keeps a small table of recent virtual-page to physical-frame translations so that most address lookups avoid a page-table access. The table is split into several ways, each holding one entry per set. A lookup compares the requested virtual page number against every way of the selected set in the same cycle and, one clock later, reports whether a translation was found and which frame it names. Only the tag and the frame number are kept; no memory contents are held.

After a miss, whoever resolves the translation (a walker or software) writes it back through the fill port. The fill reuses an entry that already holds the same page, otherwise takes an empty way of the set, and only when the set is full evicts the way that a per-set tree of pseudo-LRU bits marks as least recently used. Both fills and lookup hits count as uses. A single flush input empties the whole table at once, which is what a context switch needs.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid: `res_valid` is 0 and the first lookup of any page reports a miss.
- R2: A request with `lk_valid` high yields `res_valid` high exactly one clock later and only then; the result reflects the table as it stood at the request's clock edge.
- R3: A hit returns the frame number written by the fill for that page; a miss returns `res_hit` 0 and `res_pfn` 0.
- R4: The set is the virtual page number modulo the set count (8 by default, so the low 3 bits) and the remaining upper bits form the tag; pages that share a set but differ in tag do not hit each other, and pages in different sets do not disturb each other.
- R5: A fill of a new page into a set that has an invalid way writes an invalid way, so up to 4 distinct pages of one set stay resident together.
- R6: A fill whose page already has a valid entry rewrites that entry's frame in place and never creates a second entry for the same page.
- R7: A fill into a full set evicts the way chosen by a 3-bit tree pseudo-LRU per set, updated by every fill and every lookup hit; after filling A, B, C, D into one empty set, a fill of E evicts A, and after a later hit on B a fill of F evicts C.
- R8: A flush invalidates every entry in one cycle; every later lookup misses until a new fill.
- R9: Flush wins over a fill in the same cycle (the fill is dropped), and a lookup issued in the flush cycle reports a miss even for a resident page.
- R10: A lookup and a fill of the same page in the same cycle report a miss; the page hits on the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| res_valid | output | 1 | Lookup result present (one cycle after request) |
| res_hit | output | 1 | Translation found |
| res_pfn | output | 16 | Physical frame number on a hit, zero on a miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_pfn | input | 16 | Physical frame number being filled |

## Verification
A corrupted valid bit or tag shows at the ports on the very next lookup of that page as a wrong hit flag, and a wrong frame field shows as a wrong `res_pfn` on the cycle after that lookup. A bad replacement or empty-way choice stays hidden until the set is probed again: it appears as a miss for a page that should still be resident, so the bench reads back all pages of a set right after each fill sequence. A duplicate entry or a fill that leaks through a flush is caught by the checker on the same cycle it forms, before any lookup exposes it.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // Why a fill chose its way, exposed for the checker.
  typedef enum logic [1:0] {
    FILL_MATCH = 2'd0,
    FILL_EMPTY = 2'd1,
    FILL_EVICT = 2'd2
  } fill_src_e;
endpackage

// File: rtl/xc_way.sv
// One way of the table: valid bits, tags and frame numbers for every set,
// with a lookup read port (a), a fill-side read port (b) and one write port.
module xc_way #(
  parameter int SETS  = 8,
  parameter int TAG_W = 17,
  parameter int PFN_W = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PFN_W-1:0] a_pfn,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PFN_W-1:0] pfn_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_tag;
      pfn_q[wr_idx] <= wr_pfn;
    end
  end

  assign a_valid = vld_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_pfn   = pfn_q[a_idx];
  assign b_valid = vld_q[b_idx];
  assign b_tag   = tag_q[b_idx];
endmodule

// File: rtl/xc_plru.sv
// Per-set tree pseudo-LRU. Node n has children 2n+1 and 2n+2; a node bit
// of 1 points the victim search to the right child.
module xc_plru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] victim
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d [SETS];

  // Mark way w as most recently used: every node on its path points away.
  function automatic logic [NODES-1:0] f_touch(input logic [NODES-1:0] t,
                                               input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int n;
    int p;
    r = t;
    n = NODES + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      p = (n - 1) / 2;
      r[p] = (n == 2 * p + 1);
      n = p;
    end
    return r;
  endfunction

  // Follow the node bits from the root down to a leaf.
  function automatic logic [WAY_W-1:0] f_pick(input logic [NODES-1:0] t);
    int n;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      n = 2 * n + 1 + int'(t[n]);
    end
    return WAY_W'(n - NODES);
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) tree_d[s] = tree_q[s];
    if (hit_en)  tree_d[hit_idx]  = f_touch(tree_d[hit_idx], hit_way);
    if (fill_en) tree_d[fill_idx] = f_touch(tree_d[fill_idx], fill_way);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (!rst_n || flush) tree_q[s] <= '0;
      else                 tree_q[s] <= tree_d[s];
    end
  end

  assign victim = f_pick(tree_q[q_idx]);
endmodule

// File: rtl/xc_pick.sv
// Way selection: encodes the lookup hit and decides the fill target
// (matching entry, else lowest empty way, else the pseudo-LRU victim).
module xc_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]     lk_hit_vec,
  output logic [WAY_W-1:0]    lk_way,
  input  logic [WAYS-1:0]     fl_match_vec,
  input  logic [WAYS-1:0]     fl_valid_vec,
  input  logic [WAY_W-1:0]    fl_victim,
  output logic [WAY_W-1:0]    fl_way,
  output xc_pkg::fill_src_e   fl_src
);
  function automatic logic [WAY_W-1:0] f_enc(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) if (v[i]) r = r | WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] f_first_zero(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = WAY_W'(i);
    return r;
  endfunction

  assign lk_way = f_enc(lk_hit_vec);

  always_comb begin
    if (|fl_match_vec) begin
      fl_way = f_enc(fl_match_vec);
      fl_src = xc_pkg::FILL_MATCH;
    end else if (!(&fl_valid_vec)) begin
      fl_way = f_first_zero(fl_valid_vec);
      fl_src = xc_pkg::FILL_EMPTY;
    end else begin
      fl_way = fl_victim;
      fl_src = xc_pkg::FILL_EVICT;
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 16,
  parameter int WAYS  = 4,
  parameter int SETS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             res_valid,
  output logic             res_hit,
  output logic [PFN_W-1:0] res_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // Interleaved mapping: consecutive pages fall into consecutive sets.
  function automatic logic [IDX_W-1:0] f_idx(input logic [VPN_W-1:0] v);
    return IDX_W'(v % SETS);
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [VPN_W-1:0] v);
    return TAG_W'(v / SETS);
  endfunction

  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_idx = f_idx(lk_vpn);
  assign lk_tag = f_tag(lk_vpn);
  assign fl_idx = f_idx(fill_vpn);
  assign fl_tag = f_tag(fill_vpn);

  logic [WAYS-1:0]  a_vld, b_vld, hit_vec, match_vec, wr_vec;
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [TAG_W-1:0] b_tag [WAYS];
  logic [PFN_W-1:0] a_pfn [WAYS];

  logic             evt_lk_hit;
  logic             evt_fill;
  logic [WAY_W-1:0] lk_way, fl_way, victim;
  xc_pkg::fill_src_e fl_src;

  assign evt_lk_hit = lk_valid && (|hit_vec) && !flush;
  assign evt_fill   = fill_en && !flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xc_way #(.SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .a_idx   (lk_idx),
      .a_valid (a_vld[w]),
      .a_tag   (a_tag[w]),
      .a_pfn   (a_pfn[w]),
      .b_idx   (fl_idx),
      .b_valid (b_vld[w]),
      .b_tag   (b_tag[w]),
      .wr_en   (wr_vec[w]),
      .wr_idx  (fl_idx),
      .wr_tag  (fl_tag),
      .wr_pfn  (fill_pfn)
    );
    assign hit_vec[w]   = a_vld[w] && (a_tag[w] == lk_tag);
    assign match_vec[w] = b_vld[w] && (b_tag[w] == fl_tag);
    assign wr_vec[w]    = evt_fill && (fl_way == WAY_W'(w));
  end

  xc_pick #(.WAYS(WAYS)) u_pick (
    .lk_hit_vec   (hit_vec),
    .lk_way       (lk_way),
    .fl_match_vec (match_vec),
    .fl_valid_vec (b_vld),
    .fl_victim    (victim),
    .fl_way       (fl_way),
    .fl_src       (fl_src)
  );

  xc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .hit_en   (evt_lk_hit),
    .hit_idx  (lk_idx),
    .hit_way  (lk_way),
    .fill_en  (evt_fill),
    .fill_idx (fl_idx),
    .fill_way (fl_way),
    .q_idx    (fl_idx),
    .victim   (victim)
  );

  logic [PFN_W-1:0] hit_pfn;
  always_comb begin
    hit_pfn = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_pfn = hit_pfn | a_pfn[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= evt_lk_hit;
      res_pfn   <= evt_lk_hit ? hit_pfn : '0;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int WAYS  = 4,
  parameter int PFN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [PFN_W-1:0] res_pfn,
  input logic [WAYS-1:0]  hit_vec,
  input logic [WAYS-1:0]  match_vec,
  input logic [WAYS-1:0]  b_vld,
  input logic [WAYS-1:0]  wr_vec,
  input logic             evt_fill
);
  p_req_gives_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  p_no_req_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  p_miss_pfn_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_pfn == '0));
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit);
  p_flush_cycle_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_hit);
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (b_vld == '0));
  p_no_duplicate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec) && $onehot0(match_vec));
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  p_update_in_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fill && (match_vec != '0)) |-> (wr_vec == match_vec));
  p_empty_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fill && (match_vec == '0) && !(&b_vld)) |-> ((wr_vec & ~b_vld) != '0));
  p_fill_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |-> ($countones(wr_vec) == 1));
endmodule

bind xlate_cache xlate_cache_chk #(.WAYS(WAYS), .PFN_W(PFN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .lk_valid  (lk_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_pfn   (res_pfn),
  .hit_vec   (hit_vec),
  .match_vec (match_vec),
  .b_vld     (b_vld),
  .wr_vec    (wr_vec),
  .evt_fill  (evt_fill)
);

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;
  localparam int VPN_W = 20;
  localparam int PFN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic             lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic             res_valid, res_hit;
  logic [PFN_W-1:0] res_pfn;
  logic             fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlate_cache u_xlate_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .res_valid(res_valid), .res_hit(res_hit), .res_pfn(res_pfn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
  );

  // Page number built from a tag and a set (set = low 3 bits).
  function automatic logic [VPN_W-1:0] pg(input int tag, input int set);
    return VPN_W'(tag * 8 + set);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input bit eh,
                        input logic [PFN_W-1:0] ep, input string req);
    logic [PFN_W-1:0] e;
    e = eh ? ep : '0;
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && (res_hit == eh) && (res_pfn == e), req,
        32'({res_valid, res_hit, res_pfn}), 32'({1'b1, eh, e}));
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p);
    fill_en = 1'b1; fill_vpn = v; fill_pfn = p;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(res_valid == 1'b0, "R1 res_valid idle after reset", 32'(res_valid), 32'(0));
    lookup(pg(5, 2), 1'b0, '0, "R1 first lookup misses");
    lookup(pg(0, 0), 1'b0, '0, "R1 page zero misses");
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 no result without request", 32'(res_valid), 32'(0));
  endtask

  task automatic t_basic();
    do_flush();
    fill(pg(9, 4), 16'h1234);
    lookup(pg(9, 4), 1'b1, 16'h1234, "R3 hit returns frame");
    lookup(pg(10, 4), 1'b0, '0, "R3 miss gives zero frame");
    // Back-to-back requests: each result one cycle after its request.
    lk_valid = 1'b1; lk_vpn = pg(9, 4);
    @(negedge clk);
    chk(res_valid && res_hit && res_pfn == 16'h1234, "R2 first of pair",
        32'({res_valid, res_hit, res_pfn}), 32'({2'b11, 16'h1234}));
    lk_vpn = pg(3, 4);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && !res_hit && res_pfn == 0, "R2 second of pair",
        32'({res_valid, res_hit, res_pfn}), 32'({2'b10, 16'h0}));
  endtask

  task automatic t_index_spread();
    do_flush();
    for (int s = 0; s < 8; s++) fill(pg(100, s), PFN_W'(16'h0A00 + s));
    for (int s = 0; s < 8; s++) lookup(pg(100, s), 1'b1, PFN_W'(16'h0A00 + s), "R4 each set holds own page");
    lookup(pg(101, 3), 1'b0, '0, "R4 same set other tag misses");
    fill(20'hABCDE, 16'h7777);
    lookup(20'hABCDE, 1'b1, 16'h7777, "R4 wide page hits");
    lookup(pg(100, 6), 1'b1, 16'h0A06, "R4 neighbour in set 6 kept");
  endtask

  task automatic t_fill_empty_pref();
    do_flush();
    for (int t = 0; t < 4; t++) fill(pg(40 + t, 1), PFN_W'(16'h0B00 + t));
    for (int t = 0; t < 4; t++) lookup(pg(40 + t, 1), 1'b1, PFN_W'(16'h0B00 + t), "R5 four pages share set");
  endtask

  task automatic t_update_inplace();
    do_flush();
    fill(pg(60, 5), 16'h00AA);
    fill(pg(60, 5), 16'h00BB);
    for (int t = 1; t < 4; t++) fill(pg(60 + t, 5), PFN_W'(16'h0C00 + t));
    lookup(pg(60, 5), 1'b1, 16'h00BB, "R6 refill rewrote frame");
    for (int t = 1; t < 4; t++) lookup(pg(60 + t, 5), 1'b1, PFN_W'(16'h0C00 + t), "R6 no duplicate took a way");
  endtask

  task automatic t_replace();
    do_flush();
    fill(pg(1, 3), 16'h0001);  // A
    fill(pg(2, 3), 16'h0002);  // B
    fill(pg(3, 3), 16'h0003);  // C
    fill(pg(4, 3), 16'h0004);  // D
    fill(pg(5, 3), 16'h0005);  // E evicts A
    lookup(pg(2, 3), 1'b1, 16'h0002, "R7 B hit before F");
    fill(pg(6, 3), 16'h0006);  // F evicts C
    lookup(pg(1, 3), 1'b0, '0, "R7 A evicted by E");
    lookup(pg(3, 3), 1'b0, '0, "R7 C evicted by F");
    lookup(pg(2, 3), 1'b1, 16'h0002, "R7 B kept");
    lookup(pg(4, 3), 1'b1, 16'h0004, "R7 D kept");
    lookup(pg(5, 3), 1'b1, 16'h0005, "R7 E resident");
    lookup(pg(6, 3), 1'b1, 16'h0006, "R7 F resident");
  endtask

  task automatic t_flush();
    do_flush();
    fill(pg(7, 0), 16'h0700);
    fill(pg(8, 7), 16'h0800);
    do_flush();
    lookup(pg(7, 0), 1'b0, '0, "R8 flushed page misses");
    lookup(pg(8, 7), 1'b0, '0, "R8 flushed page misses other set");
    fill(pg(7, 0), 16'h0701);
    lookup(pg(7, 0), 1'b1, 16'h0701, "R8 refill after flush");
  endtask

  task automatic t_flush_priority();
    do_flush();
    fill(pg(30, 2), 16'h3000);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = pg(31, 2); fill_pfn = 16'h3100;
    lk_valid = 1'b1; lk_vpn = pg(30, 2);
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0; lk_valid = 1'b0;
    chk(res_valid && !res_hit && res_pfn == 0, "R9 lookup in flush cycle misses",
        32'({res_valid, res_hit, res_pfn}), 32'({2'b10, 16'h0}));
    lookup(pg(31, 2), 1'b0, '0, "R9 fill during flush dropped");
    lookup(pg(30, 2), 1'b0, '0, "R9 old page gone");
  endtask

  task automatic t_same_cycle();
    do_flush();
    lk_valid = 1'b1; lk_vpn = pg(50, 6);
    fill_en = 1'b1; fill_vpn = pg(50, 6); fill_pfn = 16'h5050;
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0;
    chk(res_valid && !res_hit && res_pfn == 0, "R10 same-cycle lookup sees old table",
        32'({res_valid, res_hit, res_pfn}), 32'({2'b10, 16'h0}));
    lookup(pg(50, 6), 1'b1, 16'h5050, "R10 next lookup hits");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_basic();
    t_index_spread();
    t_fill_empty_pref();
    t_update_inplace();
    t_replace();
    t_flush();
    t_flush_priority();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule